// File: doc/BRIEF.md
# Real-Time Clock with Alarm and Periodic Interrupts

This block is a memory-mapped timekeeping peripheral with a 16-bit synchronous register bus. A slow timebase arrives as the `ref_tick` qualifier, one pulse per period of the selected input rate (32768, 32000 or 38400 Hz). A prescaler turns that timebase into an exact 512 Hz tick. Binary division of that tick gives periodic events at every power of two from 2 Hz to 512 Hz, plus a 1 Hz update. The update advances a seconds, minutes, hours and days count.

The running time is compared against an alarm time of day, hour, minute and second. Every event sets a sticky bit in a write-one-to-clear status register. An enable mask selects which status bits drive the single `irq` output. Software reads and writes the time through the same bus. A write to any time field restarts the sub-second phase, so that a newly loaded time begins a full second before it advances.

Top module: `rtc_timekeeper`

## Requirements
- R1: Registers sit at byte addresses 0x00 (hours in bits 12:8, minutes in bits 5:0), 0x04 (seconds, bits 5:0), 0x08 (alarm hours/minutes, same packing as 0x00), 0x0C (alarm seconds), 0x10 (control: bit 7 enable, bits 6:5 rate), 0x14 (status), 0x18 (interrupt enable) and 0x20/0x24 (day count / alarm day, 16 bits). Every other address, including 0x1C, and every unimplemented bit reads 0. Read data is combinational from the address. After reset every register reads 0.
- R2: Rate field 00 divides `ref_tick` by 64, 10 divides it by 75, and 01 alternates a divide by 62 with a divide by 63, starting with 62. After a prescaler restart, the j-th 512 Hz tick falls on the 64·j-th, 75·j-th or floor(125·j/2)-th counted `ref_tick` respectively.
- R3: Status bits 15 down to 8 are the 512, 256, 128, 64, 32, 16, 8 and 4 Hz events, and bit 7 is the 2 Hz event. The event for 2^k Hz fires on every 2^(9-k)-th 512 Hz tick, counted from the prescaler restart.
- R4: Status bit 4 sets on every 512th tick (1 Hz), and that same edge advances the seconds. Seconds and minutes wrap from 59 to 0 with a carry, and hours wrap from 23 to 0 with a carry into the day count.
- R5: The 16-bit day count wraps from 0xFFFF to 0 when the hours wrap.
- R6: Status bit 2 (alarm) sets one clock edge after day, hours, minutes and seconds first become equal to the alarm registers.
- R7: Writing the status register clears exactly the bits written as 1, and leaves the others unchanged. Bits stay set until cleared.
- R8: If an event and a clearing write hit the same bit on the same edge, the bit stays set.
- R9: `irq` is high whenever a status bit and the matching enable bit are both 1. The enable register stores only bits 15:7, 4 and 2 (so 0xFFFF reads back as 0xFF94), and writing 0 to it masks every source.
- R10: A write to 0x00, 0x04 or 0x20 is visible on the next cycle, and that cycle's second advance is suppressed. The write also restarts the prescaler and the 512 Hz division, which sets the R2 count origin.
- R11: While control bit 7 is 0, the prescaler, the division chain and the time counters hold their values. Counting resumes from the held phase when the bit is set again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One pulse per period of the selected timebase rate |
| bus_addr | input | 6 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle in which it is high |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, same cycle |
| irq | output | 1 | Interrupt request, status AND enable nonzero |

## Verification
Read data is valid in the cycle of the address. A write takes effect at the edge on which its strobe is sampled. The bench records that edge and computes every later deadline from it. A periodic or 1 Hz status bit rises on the edge of the N-th counted `ref_tick` after the edge that restarted or enabled the prescaler, where N comes from the rate formula. The alarm bit rises one edge later than the time match. The bench samples on the falling edge just before and just after each computed edge, so that an early or late event shows up as a mismatch. The clearing write in the R8 test is placed so that its edge coincides with a computed tick edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 6;

  typedef enum logic [1:0] {
    RATE_32768 = 2'b00,
    RATE_32000 = 2'b01,
    RATE_38400 = 2'b10,
    RATE_SPARE = 2'b11
  } rate_e;

  localparam logic [ADDR_W-1:0] OFF_HM    = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_SEC   = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_AHM   = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_ASEC  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_IEN   = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_DAY   = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_ADAY  = 6'h24;

  localparam int unsigned BIT_ALARM  = 2;
  localparam int unsigned BIT_SEC    = 4;
  localparam int unsigned BIT_PER_LO = 7;
  localparam logic [DATA_W-1:0] IEN_MASK = 16'hFF94;

  // last count value of one 512 Hz period for the given rate and phase
  function automatic logic [6:0] div_last(rate_e r, logic odd);
    case (r)
      RATE_32000: div_last = odd ? 7'd62 : 7'd61;
      RATE_38400: div_last = 7'd74;
      default:    div_last = 7'd63;
    endcase
  endfunction

  // modulo-60 step: {carry, next}
  function automatic logic [6:0] step_sixty(logic [5:0] v);
    if (v >= 6'd59) step_sixty = {1'b1, 6'd0};
    else            step_sixty = {1'b0, v + 6'd1};
  endfunction

  // modulo-24 step: {carry, next}
  function automatic logic [5:0] step_hour(logic [4:0] v);
    if (v >= 5'd23) step_hour = {1'b1, 5'd0};
    else            step_hour = {1'b0, v + 5'd1};
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_pkg::*;
#(
  parameter int unsigned SUB_W = 9,
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  rate_e            rate,
  output logic [SUB_W-1:0] rate_evt,
  output logic             sec_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(74);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             odd_q;
  logic [SUB_W-1:0] sub_q;
  logic             tick;

  always_comb begin
    last = CNT_W'(div_last(rate, odd_q));
    tick = run && (cnt_q >= last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt_q <= '0;
      odd_q <= 1'b0;
      sub_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
      odd_q <= (rate == RATE_32000) ? ~odd_q : 1'b0;
      sub_q <= sub_q + 1'b1;
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // event for the i-th rate: every 2^(SUB_W-1-i) ticks
  for (genvar i = 0; i < SUB_W; i++) begin : g_rate
    localparam int unsigned SPAN = SUB_W - 1 - i;
    localparam logic [SUB_W-1:0] MSK = SUB_W'((1 << SPAN) - 1);
    assign rate_evt[i] = tick && ((sub_q & MSK) == MSK);
  end

  assign sec_evt = tick && (&sub_q);

  p_cnt_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  p_sec_has_rates_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |-> (&rate_evt));
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0 && sub_q == '0));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> ($stable(cnt_q) && $stable(sub_q)));
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
#(
  parameter int unsigned DAY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              wr_hm,
  input  logic              wr_sec,
  input  logic              wr_day,
  input  logic [DATA_W-1:0] wdata,
  output logic [5:0]        sec_o,
  output logic [5:0]        min_o,
  output logic [4:0]        hr_o,
  output logic [DAY_W-1:0]  day_o
);
  logic [5:0]       sec_q, min_q, sec_n, min_n;
  logic [4:0]       hr_q, hr_n;
  logic [DAY_W-1:0] day_q;
  logic             c_sec, c_min, c_hr, any_wr;

  always_comb begin
    {c_sec, sec_n} = step_sixty(sec_q);
    {c_min, min_n} = step_sixty(min_q);
    {c_hr, hr_n}   = step_hour(hr_q);
    any_wr         = wr_hm || wr_sec || wr_day;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
      day_q <= '0;
    end else if (any_wr) begin
      if (wr_hm) begin
        hr_q  <= wdata[12:8];
        min_q <= wdata[5:0];
      end
      if (wr_sec) sec_q <= wdata[5:0];
      if (wr_day) day_q <= wdata[DAY_W-1:0];
    end else if (step) begin
      sec_q <= sec_n;
      if (c_sec) min_q <= min_n;
      if (c_sec && c_min) hr_q <= hr_n;
      if (c_sec && c_min && c_hr) day_q <= day_q + 1'b1;
    end
  end

  assign sec_o = sec_q;
  assign min_o = min_q;
  assign hr_o  = hr_q;
  assign day_o = day_q;

  p_sec_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !any_wr) |=> (sec_q <= 6'd59));
  p_min_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !any_wr && sec_q == 6'd59) |=> (sec_q == 6'd0 && min_q != $past(min_q)));
  p_day_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !any_wr && sec_q == 6'd59 && min_q == 6'd59 && hr_q == 5'd23 && (&day_q))
      |=> (day_q == '0));
  p_write_vis_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sec |=> (sec_q == $past(wdata[5:0])));
endmodule

// File: rtl/rtc_irq_regs.sv
module rtc_irq_regs
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] events,
  input  logic              clr_we,
  input  logic              en_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] enable_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] status_q, enable_q, clr_bits;

  always_comb clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= (status_q & ~clr_bits) | events;
      if (en_we) enable_q <= wdata & IEN_MASK;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign irq_o    = |(status_q & enable_q);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((status_q & $past(status_q)) == $past(status_q)));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && events == '0) |=> ((status_q & $past(wdata)) == '0));
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|events) |=> ((status_q & $past(events)) == $past(events)));
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == '0) |-> !irq_o);
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
#(
  parameter int unsigned DAY_W = 16,
  parameter int unsigned SUB_W = 9,
  parameter int unsigned CNT_W = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_tick,
  input  logic [5:0]  bus_addr,
  input  logic        bus_we,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq
);
  localparam int unsigned PER_HI = BIT_PER_LO + SUB_W - 1;

  // control and alarm registers
  logic             en_q;
  rate_e            rate_q;
  logic [4:0]       alm_hr_q;
  logic [5:0]       alm_min_q, alm_sec_q;
  logic [DAY_W-1:0] alm_day_q;
  logic             match_q;

  // named internal events
  logic             wr_hm, wr_sec, wr_day, wr_ahm, wr_asec, wr_aday;
  logic             wr_ctrl, wr_stat, wr_ien, time_wr;
  logic [SUB_W-1:0] rate_evt;
  logic             sec_evt, match, alarm_evt;
  logic [DATA_W-1:0] events, stat, ien;

  logic [5:0]       t_sec, t_min;
  logic [4:0]       t_hr;
  logic [DAY_W-1:0] t_day;

  always_comb begin
    wr_hm   = bus_we && (bus_addr == OFF_HM);
    wr_sec  = bus_we && (bus_addr == OFF_SEC);
    wr_day  = bus_we && (bus_addr == OFF_DAY);
    wr_ahm  = bus_we && (bus_addr == OFF_AHM);
    wr_asec = bus_we && (bus_addr == OFF_ASEC);
    wr_aday = bus_we && (bus_addr == OFF_ADAY);
    wr_ctrl = bus_we && (bus_addr == OFF_CTRL);
    wr_stat = bus_we && (bus_addr == OFF_STAT);
    wr_ien  = bus_we && (bus_addr == OFF_IEN);
    time_wr = wr_hm || wr_sec || wr_day;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      rate_q    <= RATE_32768;
      alm_hr_q  <= '0;
      alm_min_q <= '0;
      alm_sec_q <= '0;
      alm_day_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= bus_wdata[7];
        rate_q <= rate_e'(bus_wdata[6:5]);
      end
      if (wr_ahm) begin
        alm_hr_q  <= bus_wdata[12:8];
        alm_min_q <= bus_wdata[5:0];
      end
      if (wr_asec) alm_sec_q <= bus_wdata[5:0];
      if (wr_aday) alm_day_q <= bus_wdata[DAY_W-1:0];
    end
  end

  rtc_prescaler #(.SUB_W(SUB_W), .CNT_W(CNT_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (en_q && ref_tick),
    .restart  (time_wr),
    .rate     (rate_q),
    .rate_evt (rate_evt),
    .sec_evt  (sec_evt)
  );

  rtc_time_chain #(.DAY_W(DAY_W)) u_time (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (sec_evt),
    .wr_hm  (wr_hm),
    .wr_sec (wr_sec),
    .wr_day (wr_day),
    .wdata  (bus_wdata),
    .sec_o  (t_sec),
    .min_o  (t_min),
    .hr_o   (t_hr),
    .day_o  (t_day)
  );

  // alarm fires on entry into equality; reset value avoids a reset-time hit
  always_comb begin
    match     = (t_day == alm_day_q) && (t_hr == alm_hr_q) &&
                (t_min == alm_min_q) && (t_sec == alm_sec_q);
    alarm_evt = match && !match_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) match_q <= 1'b1;
    else        match_q <= match;
  end

  always_comb begin
    events                     = '0;
    events[BIT_ALARM]          = alarm_evt;
    events[BIT_SEC]            = sec_evt;
    events[PER_HI:BIT_PER_LO]  = rate_evt;
  end

  rtc_irq_regs u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .events   (events),
    .clr_we   (wr_stat),
    .en_we    (wr_ien),
    .wdata    (bus_wdata),
    .status_o (stat),
    .enable_o (ien),
    .irq_o    (irq)
  );

  always_comb begin
    case (bus_addr)
      OFF_HM:   bus_rdata = {3'b0, t_hr, 2'b0, t_min};
      OFF_SEC:  bus_rdata = {10'b0, t_sec};
      OFF_AHM:  bus_rdata = {3'b0, alm_hr_q, 2'b0, alm_min_q};
      OFF_ASEC: bus_rdata = {10'b0, alm_sec_q};
      OFF_CTRL: bus_rdata = {8'b0, en_q, rate_q, 5'b0};
      OFF_STAT: bus_rdata = stat;
      OFF_IEN:  bus_rdata = ien;
      OFF_DAY:  bus_rdata = DATA_W'(t_day);
      OFF_ADAY: bus_rdata = DATA_W'(alm_day_q);
      default:  bus_rdata = '0;
    endcase
  end

  p_alarm_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> stat[BIT_ALARM]);
  p_sec_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |=> stat[BIT_SEC]);
  p_no_count_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (rate_evt == '0 && !sec_evt));
endmodule

// File: tb/tb_rtc_timekeeper.sv
module tb_rtc_timekeeper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int edge_n = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) edge_n <= edge_n + 1;

  rtc_timekeeper dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // call just after a falling edge; returns the edge on which the write landed
  task automatic wr(input logic [5:0] a, input logic [15:0] d, output int landed);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    landed = edge_n;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wait_until(input int e);
    while (edge_n < e) @(negedge clk);
  endtask

  // periodic status bits expected after j ticks of 512 Hz
  function automatic logic [15:0] exp_per(input int j);
    logic [15:0] v = '0;
    for (int k = 1; k <= 9; k++)
      if (j >= (1 << (9 - k))) v[k + 6] = 1'b1;
    return v;
  endfunction

  function automatic int cum(input int r, input int j);
    if (r == 1) return (j * 125) / 2;
    if (r == 2) return 75 * j;
    return 64 * j;
  endfunction

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    int e, p, d, f;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and map
    rd(6'h10, v); check("R1 ctrl reset", v, 16'h0000);
    rd(6'h14, v); check("R1 status reset", v, 16'h0000);
    rd(6'h00, v); check("R1 hm reset", v, 16'h0000);
    check("R1 irq reset", {15'b0, irq}, 16'h0000);
    wr(6'h10, 16'h007F, e);
    rd(6'h10, v); check("R1 ctrl readback", v, 16'h0060);
    rd(6'h1C, v); check("R1 unmapped 0x1C", v, 16'h0000);
    rd(6'h3C, v); check("R1 unmapped 0x3C", v, 16'h0000);

    // R2/R3 sweep over the three rates
    for (int r = 0; r < 3; r++) begin
      int en_edge;
      wr(6'h10, 16'(r << 5), e);
      wr(6'h04, 16'h0000, e);
      wr(6'h14, 16'hFFFF, e);
      wr(6'h10, 16'h0080 | 16'(r << 5), en_edge);
      for (int j = 1; j <= 8; j++) begin
        wait_until(en_edge + cum(r, j) - 1);
        rd(6'h14, v); check("R2 before tick", v, exp_per(j - 1));
        wait_until(en_edge + cum(r, j));
        rd(6'h14, v); check("R3 at tick", v, exp_per(j));
      end
      if (r == 0) begin
        wr(6'h14, 16'h4000, e);
        rd(6'h14, v); check("R7 partial clear", v, 16'hB000);
        wr(6'h18, 16'hFFFF, e);
        rd(6'h18, v); check("R9 enable mask", v, 16'hFF94);
        check("R9 irq on", {15'b0, irq}, 16'h0001);
        wr(6'h18, 16'h0000, e);
        check("R9 irq masked", {15'b0, irq}, 16'h0000);
      end
    end

    // R11 hold while disabled
    wr(6'h10, 16'h0080, e);
    wr(6'h04, 16'h0000, p);
    wr(6'h14, 16'hFFFF, e);
    wait_until(p + 20);
    wr(6'h10, 16'h0000, d);
    wait_until(d + 40);
    rd(6'h14, v); check("R11 no tick while off", v, 16'h0000);
    rd(6'h04, v); check("R11 seconds held", v, 16'h0000);
    wr(6'h10, 16'h0080, f);
    wait_until(f + (64 - (d - p)) - 1);
    rd(6'h14, v); check("R11 resume early", v, 16'h0000);
    wait_until(f + (64 - (d - p)));
    rd(6'h14, v); check("R11 resume tick", v, 16'h8000);

    // R8 set wins against a clear on the same edge
    wait_until(f + (64 - (d - p)) + 63);
    wr(6'h14, 16'h8000, e);
    rd(6'h14, v); check("R8 set wins", v, 16'hC000);
    wr(6'h14, 16'hC000, e);
    rd(6'h14, v); check("R7 clear all", v, 16'h0000);

    // R4/R5/R6/R10 full rollover with alarm
    wr(6'h10, 16'h0000, e);
    wr(6'h20, 16'hFFFF, e);
    rd(6'h20, v); check("R10 day write", v, 16'hFFFF);
    wr(6'h00, 16'h173B, e);
    rd(6'h00, v); check("R10 hm write", v, 16'h173B);
    wr(6'h04, 16'h003B, e);
    rd(6'h04, v); check("R10 sec write", v, 16'h003B);
    wr(6'h0C, 16'h002A, e);
    rd(6'h0C, v); check("R1 alarm sec", v, 16'h002A);
    wr(6'h0C, 16'h0000, e);
    wr(6'h08, 16'h0000, e);
    wr(6'h24, 16'h0000, e);
    wr(6'h14, 16'hFFFF, e);
    wr(6'h18, 16'h0014, e);
    wr(6'h10, 16'h0080, p);
    wait_until(p + 32767);
    rd(6'h04, v); check("R4 before second", v, 16'h003B);
    check("R9 irq idle", {15'b0, irq}, 16'h0000);
    wait_until(p + 32768);
    rd(6'h04, v); check("R4 sec wrap", v, 16'h0000);
    rd(6'h00, v); check("R4 hm wrap", v, 16'h0000);
    rd(6'h20, v); check("R5 day wrap", v, 16'h0000);
    rd(6'h14, v); check("R4 status at second", v, 16'hFF90);
    check("R9 irq second", {15'b0, irq}, 16'h0001);
    wait_until(p + 32769);
    rd(6'h14, v); check("R6 alarm set", v, 16'hFF94);

    // R4 minute carry at 38400 Hz, no alarm
    wr(6'h10, 16'h0040, e);
    wr(6'h04, 16'h003B, e);
    wr(6'h14, 16'hFFFF, e);
    wr(6'h10, 16'h00C0, p);
    wait_until(p + 38399);
    rd(6'h00, v); check("R4 min before", v, 16'h0000);
    wait_until(p + 38400);
    rd(6'h00, v); check("R4 min carry", v, 16'h0001);
    rd(6'h04, v); check("R4 sec zero", v, 16'h0000);
    rd(6'h14, v); check("R6 no alarm", v & 16'h0014, 16'h0010);

    done = 1'b1;
    finish_run();
  end
endmodule